// File: doc/BRIEF.md
# Striped Page Allocator

This block maps logical flash pages to physical pages for an array of independent buses, each carrying several flash chips. Every logical write is given a fresh physical page. The chip that receives it comes from a fixed rotation over all bus/chip pairs, so a stream of writes spreads across the whole array. The block keeps one mapping entry per logical page. When a logical page is written again, the physical page it used to point at is marked stale.

Reads are answered from the same table one cycle later, with a flag that tells whether the page was ever written. Each physical page holds a two-bit state, and a combinational probe port reads it out for the garbage collector. When the chip under the rotation pointer has no free page left, the block raises a collection request for that chip and holds off writes. The collector erases one block of that chip and signals completion, and writing then resumes at page 0 of that block.

Top module: `salloc_top`

## Requirements
- R1: The rotation pointer visits (bus, chip) pairs with the bus index advancing fastest: (0,0), (1,0), …, (N_BUS-1,0), (0,1), …, then wraps. Only an accepted write moves it. Physical page number = ((bus·N_CHIP + chip)·BLKS + block)·PGS + page.
- R2: Each chip writes its pages in rising page order within a block, then in rising block order. The chip's pointer starts at block 0, page 0.
- R3: Rewriting a logical page that is already mapped sets the state of its previous physical page to stale (code 2).
- R4: After reset every physical page reads free (code 0). A page handed out by a write reads valid (code 1).
- R5: A read request returns rd_ack one cycle later. On that cycle rd_hit=1 and rd_ppn=current mapping if the logical page was ever written, and rd_hit=0 and rd_ppn=0 if it was not.
- R6: While the targeted chip has no free page, gc_req=1 and gc_bus/gc_chip name that chip. In that state wr_ready=0, no write is accepted and no acknowledgement appears.
- R7: gc_done together with gc_blk while gc_req=1 makes every page of that block of the requesting chip free. It gives the chip PGS free pages again, moves its pointer to page 0 of that block, and drops gc_req.
- R8: An accepted write (wr_valid and wr_ready) produces wr_ack one cycle later, with wr_ppn set to the assigned physical page.
- R9: gc_done has no effect while gc_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_lpn | input | LW | Logical page to write |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_ack | output | 1 | Write accepted on the previous cycle |
| wr_ppn | output | PPN_W | Physical page assigned to that write |
| rd_valid | input | 1 | Lookup request |
| rd_lpn | input | LW | Logical page to look up |
| rd_ack | output | 1 | Lookup result valid |
| rd_hit | output | 1 | Logical page is mapped |
| rd_ppn | output | PPN_W | Mapped physical page, 0 when unmapped |
| gc_req | output | 1 | Targeted chip is out of free pages |
| gc_bus | output | BW | Bus of the chip needing collection |
| gc_chip | output | CW | Chip index on that bus |
| gc_done | input | 1 | Collector finished erasing a block |
| gc_blk | input | KW | Block the collector erased |
| probe_ppn | input | PPN_W | Physical page whose state is read |
| probe_state | output | 2 | State of that page: 0 free, 1 valid, 2 stale |

## Verification
On every cycle the checker enforces the write and read handshake timing, that a write only lands on a page that is currently free, and that a collection request persists on the same chip until completion. The exact rotation order, the per-chip page order, the stale marking of rewritten pages and the resumption point after an erase depend on long write histories. Only the bench's reference model can show these, by replaying a full fill of the array, a stall, an ignored and an honoured completion, and the next exhaustion.

// File: rtl/salloc_pkg.sv
package salloc_pkg;
   typedef enum logic [1:0] {
      PG_FREE  = 2'd0,
      PG_VALID = 2'd1,
      PG_STALE = 2'd2
   } pg_state_e;
endpackage

// File: rtl/salloc_sweep.sv
// Rotation pointer over (bus, chip); bus index advances fastest.
module salloc_sweep #(
   parameter int N_BUS  = 2,
   parameter int N_CHIP = 2,
   parameter int BW     = 1,
   parameter int CW     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [BW-1:0] bus,
   output logic [CW-1:0] chip
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus  <= '0;
         chip <= '0;
      end else if (step) begin
         if (bus == BW'(N_BUS - 1)) begin
            bus  <= '0;
            chip <= (chip == CW'(N_CHIP - 1)) ? '0 : chip + 1'b1;
         end else begin
            bus <= bus + 1'b1;
         end
      end
   end
endmodule

// File: rtl/salloc_chip_ctr.sv
// Per-chip write pointer (block, page) and free-page count.
module salloc_chip_ctr #(
   parameter int BLKS = 2,
   parameter int PGS  = 4,
   parameter int KW   = 1,
   parameter int GW   = 2,
   parameter int FW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          reclaim,
   input  logic [KW-1:0] reclaim_blk,
   output logic [KW-1:0] blk,
   output logic [GW-1:0] pg,
   output logic          empty
);
   logic [FW-1:0] free_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk      <= '0;
         pg       <= '0;
         free_cnt <= FW'(BLKS * PGS);
      end else if (reclaim) begin
         blk      <= reclaim_blk;
         pg       <= '0;
         free_cnt <= FW'(PGS);
      end else if (take) begin
         free_cnt <= free_cnt - 1'b1;
         if (pg == GW'(PGS - 1)) begin
            pg  <= '0;
            blk <= (blk == KW'(BLKS - 1)) ? '0 : blk + 1'b1;
         end else begin
            pg <= pg + 1'b1;
         end
      end
   end

   assign empty = (free_cnt == '0);
endmodule

// File: rtl/salloc_map.sv
// Page-level logical-to-physical table, two combinational lookup ports.
module salloc_map #(
   parameter int N_LPAGE = 16,
   parameter int LW      = 4,
   parameter int PPN_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [LW-1:0]    waddr,
   input  logic [PPN_W-1:0] wdata,
   input  logic [LW-1:0]    qa_addr,
   output logic             qa_hit,
   output logic [PPN_W-1:0] qa_ppn,
   input  logic [LW-1:0]    qb_addr,
   output logic             qb_hit,
   output logic [PPN_W-1:0] qb_ppn
);
   logic [N_LPAGE-1:0] mapped;
   logic [PPN_W-1:0]   tbl [N_LPAGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mapped        <= '0;
      else if (we) mapped[waddr] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) tbl[waddr] <= wdata;
   end

   assign qa_hit = mapped[qa_addr];
   assign qa_ppn = tbl[qa_addr];
   assign qb_hit = mapped[qb_addr];
   assign qb_ppn = tbl[qb_addr];
endmodule

// File: rtl/salloc_top.sv
module salloc_top #(
   parameter int N_BUS   = 2,
   parameter int N_CHIP  = 2,
   parameter int BLKS    = 2,
   parameter int PGS     = 4,
   parameter int N_LPAGE = 16,
   localparam int NCHIPS = N_BUS * N_CHIP,
   localparam int NPAGE  = NCHIPS * BLKS * PGS,
   localparam int PPN_W  = $clog2(NPAGE),
   localparam int LW     = $clog2(N_LPAGE),
   localparam int BW     = (N_BUS > 1) ? $clog2(N_BUS) : 1,
   localparam int CW     = (N_CHIP > 1) ? $clog2(N_CHIP) : 1,
   localparam int KW     = (BLKS > 1) ? $clog2(BLKS) : 1,
   localparam int GW     = (PGS > 1) ? $clog2(PGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [LW-1:0]    wr_lpn,
   output logic             wr_ready,
   output logic             wr_ack,
   output logic [PPN_W-1:0] wr_ppn,
   input  logic             rd_valid,
   input  logic [LW-1:0]    rd_lpn,
   output logic             rd_ack,
   output logic             rd_hit,
   output logic [PPN_W-1:0] rd_ppn,
   output logic             gc_req,
   output logic [BW-1:0]    gc_bus,
   output logic [CW-1:0]    gc_chip,
   input  logic             gc_done,
   input  logic [KW-1:0]    gc_blk,
   input  logic [PPN_W-1:0] probe_ppn,
   output logic [1:0]       probe_state
);
   import salloc_pkg::*;

   localparam int FW = $clog2(BLKS * PGS + 1);

   generate
      if (N_BUS < 1 || N_BUS > 4) begin : g_bad_bus
         $error("N_BUS must be 1..4");
      end
      if (N_CHIP < 1 || N_CHIP > 4) begin : g_bad_chip
         $error("N_CHIP must be 1..4");
      end
      if (N_LPAGE < 2 || N_LPAGE > NPAGE) begin : g_bad_lpage
         $error("N_LPAGE must be 2..physical page count");
      end
      if (BLKS < 1 || PGS < 1) begin : g_bad_geom
         $error("BLKS and PGS must be positive");
      end
   endgenerate

   logic [BW-1:0] sw_bus;
   logic [CW-1:0] sw_chip;
   int            tgt_i;
   logic          accept;
   logic          reclaim_ok;

   logic [KW-1:0] cblk  [NCHIPS];
   logic [GW-1:0] cpg   [NCHIPS];
   logic          cempty[NCHIPS];

   logic             old_hit, rd_q_hit;
   logic [PPN_W-1:0] old_ppn, rd_q_ppn, new_ppn;

   pg_state_e pst [NPAGE];

   assign tgt_i      = int'(sw_bus) * N_CHIP + int'(sw_chip);
   assign gc_req     = cempty[tgt_i];
   assign gc_bus     = sw_bus;
   assign gc_chip    = sw_chip;
   assign wr_ready   = !gc_req;
   assign accept     = wr_valid && wr_ready;
   assign reclaim_ok = gc_done && gc_req;
   assign new_ppn    = PPN_W'((tgt_i * BLKS + int'(cblk[tgt_i])) * PGS + int'(cpg[tgt_i]));

   salloc_sweep #(.N_BUS(N_BUS), .N_CHIP(N_CHIP), .BW(BW), .CW(CW)) u_sweep (
      .clk (clk),
      .rst_n(rst_n),
      .step(accept),
      .bus (sw_bus),
      .chip(sw_chip)
   );

   generate
      for (genvar c = 0; c < NCHIPS; c++) begin : g_chip
         salloc_chip_ctr #(.BLKS(BLKS), .PGS(PGS), .KW(KW), .GW(GW), .FW(FW)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (accept && (tgt_i == c)),
            .reclaim    (reclaim_ok && (tgt_i == c)),
            .reclaim_blk(gc_blk),
            .blk        (cblk[c]),
            .pg         (cpg[c]),
            .empty      (cempty[c])
         );
      end
   endgenerate

   salloc_map #(.N_LPAGE(N_LPAGE), .LW(LW), .PPN_W(PPN_W)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (accept),
      .waddr  (wr_lpn),
      .wdata  (new_ppn),
      .qa_addr(wr_lpn),
      .qa_hit (old_hit),
      .qa_ppn (old_ppn),
      .qb_addr(rd_lpn),
      .qb_hit (rd_q_hit),
      .qb_ppn (rd_q_ppn)
   );

   // Physical page state: new page valid, displaced page stale, erased block free.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPAGE; i++) pst[i] <= PG_FREE;
      end else if (accept) begin
         pst[new_ppn] <= PG_VALID;
         if (old_hit) pst[old_ppn] <= PG_STALE;
      end else if (reclaim_ok) begin
         for (int p = 0; p < PGS; p++)
            pst[(tgt_i * BLKS + int'(gc_blk)) * PGS + p] <= PG_FREE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ack <= 1'b0;
         wr_ppn <= '0;
         rd_ack <= 1'b0;
         rd_hit <= 1'b0;
         rd_ppn <= '0;
      end else begin
         wr_ack <= accept;
         if (accept) wr_ppn <= new_ppn;
         rd_ack <= rd_valid;
         rd_hit <= rd_valid && rd_q_hit;
         rd_ppn <= (rd_valid && rd_q_hit) ? rd_q_ppn : '0;
      end
   end

   assign probe_state = pst[probe_ppn];
endmodule

// File: rtl/salloc_chk.sv
module salloc_chk #(
   parameter int BW = 1,
   parameter int CW = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          wr_ack,
   input logic          rd_valid,
   input logic          rd_ack,
   input logic          rd_hit,
   input logic          gc_req,
   input logic          gc_done,
   input logic [BW-1:0] gc_bus,
   input logic [CW-1:0] gc_chip,
   input logic [1:0]    tgt_state
);
   // R8
   a_r8_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> wr_ack);
   // R8
   a_r8_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_ready) |=> !wr_ack);
   // R4
   a_r4_alloc_free_page: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> (tgt_state == 2'd0));
   // R6
   a_r6_gc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_req && !gc_done) |=> (gc_req && $stable(gc_bus) && $stable(gc_chip)));
   // R5
   a_r5_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_ack);
   // R5
   a_r5_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> rd_ack);
endmodule

bind salloc_top salloc_chk #(.BW(BW), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .wr_ack   (wr_ack),
   .rd_valid (rd_valid),
   .rd_ack   (rd_ack),
   .rd_hit   (rd_hit),
   .gc_req   (gc_req),
   .gc_done  (gc_done),
   .gc_bus   (gc_bus),
   .gc_chip  (gc_chip),
   .tgt_state(pst[new_ppn])
);

// File: tb/salloc_top_bench.sv
`timescale 1ns/1ps
module salloc_top_bench;
   localparam int NB = 2, NC = 2, BLKS = 2, PGS = 4, NL = 16;
   localparam int NCH = NB * NC;
   localparam int NP = NCH * BLKS * PGS;

   logic       clk = 0, rst_n = 0;
   logic       wr_valid = 0, rd_valid = 0, gc_done = 0;
   logic [3:0] wr_lpn = 0, rd_lpn = 0;
   logic       gc_blk = 0;
   logic [4:0] probe_ppn = 0;
   logic       wr_ready, wr_ack, rd_ack, rd_hit, gc_req;
   logic [4:0] wr_ppn, rd_ppn;
   logic       gc_bus, gc_chip;
   logic [1:0] probe_state;

   always #2 clk = ~clk;

   salloc_top #(.N_BUS(NB), .N_CHIP(NC), .BLKS(BLKS), .PGS(PGS), .N_LPAGE(NL)) u_salloc_top (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_lpn(wr_lpn), .wr_ready(wr_ready),
      .wr_ack(wr_ack), .wr_ppn(wr_ppn),
      .rd_valid(rd_valid), .rd_lpn(rd_lpn), .rd_ack(rd_ack),
      .rd_hit(rd_hit), .rd_ppn(rd_ppn),
      .gc_req(gc_req), .gc_bus(gc_bus), .gc_chip(gc_chip),
      .gc_done(gc_done), .gc_blk(gc_blk),
      .probe_ppn(probe_ppn), .probe_state(probe_state)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model
   int m_bus = 0, m_chip = 0;
   int m_blk [NCH], m_pg [NCH], m_free [NCH];
   int m_map [NL];
   int m_st  [NP];
   int exp_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wr_ack) begin
         if (exp_q.size() == 0) chk(0, "R8/R6 unexpected wr_ack", 1, 0);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(wr_ppn == e, "R1/R2/R8 wr_ppn", wr_ppn, e);
         end
      end
   end

   task automatic do_write(input int lpn);
      int t, p;
      @(negedge clk);
      t = m_bus * NC + m_chip;
      wr_valid = 1; wr_lpn = lpn[3:0];
      #1;
      chk(wr_ready == 1, "R6 ready with free pages", wr_ready, 1);
      p = (t * BLKS + m_blk[t]) * PGS + m_pg[t];
      exp_q.push_back(p);
      if (m_map[lpn] >= 0) m_st[m_map[lpn]] = 2;
      m_st[p] = 1;
      m_map[lpn] = p;
      m_free[t]--;
      if (m_pg[t] == PGS - 1) begin
         m_pg[t] = 0;
         m_blk[t] = (m_blk[t] == BLKS - 1) ? 0 : m_blk[t] + 1;
      end else m_pg[t]++;
      if (m_bus == NB - 1) begin
         m_bus = 0;
         m_chip = (m_chip == NC - 1) ? 0 : m_chip + 1;
      end else m_bus++;
      @(negedge clk);
      wr_valid = 0;
   endtask

   task automatic do_read(input int lpn, input string req);
      @(negedge clk);
      rd_valid = 1; rd_lpn = lpn[3:0];
      @(negedge clk);
      rd_valid = 0;
      chk(rd_ack == 1, req, rd_ack, 1);
      chk(rd_hit == (m_map[lpn] >= 0), req, rd_hit, m_map[lpn] >= 0);
      chk(int'(rd_ppn) == ((m_map[lpn] >= 0) ? m_map[lpn] : 0), req, rd_ppn,
          (m_map[lpn] >= 0) ? m_map[lpn] : 0);
   endtask

   task automatic probe_all(input string req);
      for (int i = 0; i < NP; i++) begin
         probe_ppn = i[4:0];
         #1;
         chk(int'(probe_state) == m_st[i], req, probe_state, m_st[i]);
      end
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) begin m_blk[i] = 0; m_pg[i] = 0; m_free[i] = BLKS * PGS; end
      for (int i = 0; i < NL; i++) m_map[i] = -1;
      for (int i = 0; i < NP; i++) m_st[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(wr_ready == 1, "R6 ready after reset", wr_ready, 1);
      chk(gc_req == 0, "R6 no gc after reset", gc_req, 0);
      chk(wr_ack == 0 && rd_ack == 0, "R8 idle after reset", wr_ack, 0);
      probe_all("R4 reset free");
      do_read(3, "R5 unmapped lookup");
      // R9: completion without request must not move chip 0 pointer
      @(negedge clk); gc_done = 1; gc_blk = 1;
      @(negedge clk); gc_done = 0;
      do_write(0);
      do_read(0, "R9 pointer unchanged by stray gc_done");
      // first fill: rotation R1, page order R2
      for (int l = 1; l < NL; l++) do_write(l);
      for (int l = 0; l < NL; l++) do_read(l, "R5 mapped lookup");
      probe_all("R4 valid after write");
      // second pass: overwrite all, stale marking R3
      for (int l = 0; l < NL; l++) do_write(l);
      probe_all("R3/R4 stale and valid states");
      do_read(4, "R5 remapped lookup");
      // chip (0,0) now exhausted: R6
      @(negedge clk);
      chk(gc_req == 1, "R6 gc_req", gc_req, 1);
      chk(gc_bus == 0 && gc_chip == 0, "R6 gc target bus0 chip0", {gc_bus, gc_chip}, 0);
      wr_valid = 1; wr_lpn = 3;
      #1;
      chk(wr_ready == 0, "R6 stall", wr_ready, 0);
      @(negedge clk);
      wr_valid = 0;
      chk(wr_ack == 0, "R6 no ack while stalled", wr_ack, 0);
      do_read(3, "R6 mapping untouched by stalled write");
      // collection completes on block 0 of chip 0: R7
      @(negedge clk); gc_done = 1; gc_blk = 0;
      @(negedge clk); gc_done = 0;
      for (int p = 0; p < PGS; p++) m_st[p] = 0;
      m_blk[0] = 0; m_pg[0] = 0; m_free[0] = PGS;
      chk(gc_req == 0, "R7 gc_req dropped", gc_req, 1'b0);
      probe_all("R7 erased block free");
      do_write(7);
      do_read(7, "R7 resumes at page 0 of erased block");
      // next target (1,0) also exhausted
      @(negedge clk);
      chk(gc_req == 1, "R6 next chip gc_req", gc_req, 1);
      chk(gc_bus == 1 && gc_chip == 0, "R6 gc target bus1 chip0", {gc_bus, gc_chip}, 2);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all writes acknowledged", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL R8 watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule